// File: doc/BRIEF.md
# Control Register Write-Guard with Block Lock

This block owns the device control register and acts as the gatekeeper for every write aimed at the memory array, the potentiometer wipers and the control register itself. The bus controller hands it already-decoded write commands: a kind, an address and an 8-bit data value. The block returns one verdict per command that says whether the write may proceed. The control register holds two volatile enable latches, two monitor status flags and a two-bit lock code. Control-register contents can change only after a fixed three-step unlock. A nonzero lock code freezes the wipers and protects a region at the top of the memory array.

Commands enter on a valid/ready stream. `cmd_ready` is low while the supply is reported down and for the first cycle after it returns, and a command is taken only on a cycle where both `cmd_valid` and `cmd_ready` are high. The sender must hold a command until it is taken. Verdicts leave on a result stream that has no back-pressure. `res_valid` pulses for exactly one cycle, one clock after the command was taken, so the consumer must capture it on that cycle. The hardware write-protect pin and the two monitor comparator outputs are plain level inputs. A low `supply_ok` models a power cycle: volatile state is lost and the lock code survives.

Top module: `ctlg_top`

## Requirements
- R1: After reset, `cr_q` reads 00h and `res_valid` is low. Once `supply_ok` has been high for one clock, `cmd_ready` is high.
- R2: A control write (kind 0) of 02h sets the write-enable latch, bit 1 of `cr_q`. The bit is visible on the clock edge that takes the command.
- R3: A control write of 06h sets the register-unlock latch (bit 2) only if bit 1 is already set. Otherwise it leaves `cr_q` unchanged and reports `res_ok` low.
- R4: A control write taken while bit 2 is set is the commit. It loads the lock code (bits 4:3) and the flags (bits 5 and 6) from the data and clears bits 1 and 2. A control write that is neither 02h, nor a valid 06h, nor a commit leaves `cr_q` unchanged.
- R5: A wiper write (kind 1) is granted only when bit 1 is set, the lock code is 00 and `wp` is low.
- R6: A memory write (kind 2) is refused while bit 1 is clear.
- R7: The lock code controls memory writes as follows:
  - 00 protects nothing.
  - 01 protects addresses at or above DEPTH*3/4.
  - 10 protects addresses at or above DEPTH/2.
  - 11 protects every address.
- R8: While `wp` is high, wiper and memory writes are refused, and a commit keeps the old lock code while still loading the flags and clearing bits 1 and 2.
- R9: A rising edge on `mon2_fail` clears bit 5, and a rising edge on `mon3_fail` clears bit 6. A level that stays high does not clear a flag that software set later.
- R10: While `supply_ok` is low, bits 1, 2, 5 and 6 are cleared, the lock code is kept, `cmd_ready` is low and no command is taken.
- R11: Each taken command produces exactly one `res_valid` pulse on the following cycle. The pulse echoes the kind, address and data and carries the verdict in `res_ok`. Kind 3 is always refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Low models loss of supply |
| wp | input | 1 | Hardware write-protect |
| mon2_fail | input | 1 | Monitor 2 comparator output |
| mon3_fail | input | 1 | Monitor 3 comparator output |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken |
| cmd_kind | input | 2 | 0 control, 1 wiper, 2 memory, 3 none |
| cmd_addr | input | AW | Memory address (AW = clog2 DEPTH) |
| cmd_data | input | 8 | Data value |
| res_valid | output | 1 | Verdict pulse |
| res_ok | output | 1 | Write granted / register changed |
| res_kind | output | 2 | Echoed kind |
| res_addr | output | AW | Echoed address |
| res_data | output | 8 | Echoed data |
| cr_q | output | 8 | Control register contents |

## Verification
The bench builds the block with DEPTH set to 64, so AW is 6. That places the quarter and half lock boundaries at addresses 48 and 32. Both boundaries, and the last address 63, can be probed from either side with a few directed writes. The small depth keeps every lock code and its boundary addresses reachable in short tests, while the three-step unlock, write-protect, monitor-edge and supply-loss sequences run in full.

// File: rtl/ctlg_pkg.sv
package ctlg_pkg;
  typedef enum logic [1:0] {
    KIND_CTRL  = 2'd0,
    KIND_WIPER = 2'd1,
    KIND_MEM   = 2'd2,
    KIND_NONE  = 2'd3
  } ctlg_kind_e;

  localparam int BIT_WEL  = 1;
  localparam int BIT_RWEL = 2;
  localparam int BIT_LK0  = 3;
  localparam int BIT_LK1  = 4;
  localparam int BIT_F2   = 5;
  localparam int BIT_F3   = 6;

  localparam logic [7:0] CODE_ARM    = 8'h02;
  localparam logic [7:0] CODE_UNLOCK = 8'h06;
endpackage

// File: rtl/ctlg_creg.sv
module ctlg_creg
  import ctlg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_ok,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wp,
  input  logic       mon2,
  input  logic       mon3,
  output logic [7:0] cr
);
  logic       wel, rwel, f2, f3;
  logic [1:0] lock;
  logic       mon2_q, mon3_q;
  logic       rise2, rise3;

  assign rise2 = mon2 & ~mon2_q;
  assign rise3 = mon3 & ~mon3_q;

  // enable latches and lock code
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel  <= 1'b0;
      rwel <= 1'b0;
      lock <= 2'b00;
    end else if (!pwr_ok) begin
      wel  <= 1'b0;
      rwel <= 1'b0;
    end else if (wr_en) begin
      if (rwel) begin
        wel  <= 1'b0;
        rwel <= 1'b0;
        if (!wp) lock <= wr_data[BIT_LK1:BIT_LK0];
      end else if (wr_data == CODE_ARM) begin
        wel <= 1'b1;
      end else if (wr_data == CODE_UNLOCK && wel) begin
        rwel <= 1'b1;
      end
    end
  end

  // monitor flags: set by commit, cleared by comparator rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f2     <= 1'b0;
      f3     <= 1'b0;
      mon2_q <= 1'b0;
      mon3_q <= 1'b0;
    end else begin
      mon2_q <= mon2;
      mon3_q <= mon3;
      if (!pwr_ok) begin
        f2 <= 1'b0;
        f3 <= 1'b0;
      end else begin
        if (wr_en && rwel) begin
          f2 <= wr_data[BIT_F2];
          f3 <= wr_data[BIT_F3];
        end
        if (rise2) f2 <= 1'b0;
        if (rise3) f3 <= 1'b0;
      end
    end
  end

  always_comb begin
    cr                        = 8'h00;
    cr[BIT_WEL]               = wel;
    cr[BIT_RWEL]              = rwel;
    cr[BIT_LK1:BIT_LK0]       = lock;
    cr[BIT_F2]                = f2;
    cr[BIT_F3]                = f3;
  end
endmodule

// File: rtl/ctlg_perm.sv
module ctlg_perm
  import ctlg_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
)(
  input  logic [1:0]    kind,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    data,
  input  logic [7:0]    cr,
  input  logic          wp,
  output logic          ok
);
  localparam int BASE_Q = DEPTH - DEPTH / 4;
  localparam int BASE_H = DEPTH / 2;

  ctlg_kind_e kind_e;
  logic [AW:0] open_top;
  logic        wel, rwel;
  logic [1:0]  lock;

  assign kind_e = ctlg_kind_e'(kind);
  assign wel    = cr[BIT_WEL];
  assign rwel   = cr[BIT_RWEL];
  assign lock   = cr[BIT_LK1:BIT_LK0];

  always_comb begin
    case (lock)
      2'b00:   open_top = (AW+1)'(DEPTH);
      2'b01:   open_top = (AW+1)'(BASE_Q);
      2'b10:   open_top = (AW+1)'(BASE_H);
      default: open_top = '0;
    endcase
  end

  always_comb begin
    case (kind_e)
      KIND_CTRL:  ok = rwel || (data == CODE_ARM) || (data == CODE_UNLOCK && wel);
      KIND_WIPER: ok = wel && !wp && (lock == 2'b00);
      KIND_MEM:   ok = wel && !wp && ({1'b0, addr} < open_top);
      default:    ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/ctlg_top.sv
module ctlg_top
  import ctlg_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_ok,
  input  logic          wp,
  input  logic          mon2_fail,
  input  logic          mon3_fail,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_kind,
  input  logic [AW-1:0] cmd_addr,
  input  logic [7:0]    cmd_data,
  output logic          res_valid,
  output logic          res_ok,
  output logic [1:0]    res_kind,
  output logic [AW-1:0] res_addr,
  output logic [7:0]    res_data,
  output logic [7:0]    cr_q
);
  logic pwr_q;
  logic take;
  logic grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_q <= 1'b0;
    else        pwr_q <= supply_ok;
  end

  assign cmd_ready = pwr_q & supply_ok;
  assign take      = cmd_valid & cmd_ready;

  ctlg_creg u_creg (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_ok  (supply_ok),
    .wr_en   (take && cmd_kind == KIND_CTRL),
    .wr_data (cmd_data),
    .wp      (wp),
    .mon2    (mon2_fail),
    .mon3    (mon3_fail),
    .cr      (cr_q)
  );

  ctlg_perm #(.DEPTH(DEPTH)) u_perm (
    .kind (cmd_kind),
    .addr (cmd_addr),
    .data (cmd_data),
    .cr   (cr_q),
    .wp   (wp),
    .ok   (grant)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_ok    <= 1'b0;
      res_kind  <= 2'd0;
      res_addr  <= '0;
      res_data  <= 8'h00;
    end else begin
      res_valid <= take;
      if (take) begin
        res_ok   <= grant;
        res_kind <= cmd_kind;
        res_addr <= cmd_addr;
        res_data <= cmd_data;
      end
    end
  end
endmodule

// File: rtl/ctlg_chk.sv
module ctlg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic       wp,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_kind,
  input logic       res_valid,
  input logic       res_ok,
  input logic [1:0] res_kind,
  input logic [7:0] cr_q
);
  a_r3_unlock_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cr_q[2]) |-> $past(cr_q[1]));

  a_r4_lock_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cr_q[4:3]) |-> ($past(cr_q[2]) && $past(cmd_valid && cmd_ready && cmd_kind == 2'd0)));

  a_r5_wiper_grant_rules: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ok && res_kind == 2'd1) |-> ($past(cr_q[1]) && $past(cr_q[4:3]) == 2'b00 && !$past(wp)));

  a_r6_mem_grant_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ok && res_kind == 2'd2) |-> ($past(cr_q[1]) && !$past(wp)));

  a_r8_wp_freezes_lock: assert property (@(posedge clk) disable iff (!rst_n)
    wp |=> $stable(cr_q[4:3]));

  a_r10_supply_loss_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (cr_q[2:1] == 2'b00 && !cmd_ready));

  a_r11_result_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(cmd_valid && cmd_ready));
endmodule

bind ctlg_top ctlg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .supply_ok (supply_ok),
  .wp        (wp),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_kind  (cmd_kind),
  .res_valid (res_valid),
  .res_ok    (res_ok),
  .res_kind  (res_kind),
  .cr_q      (cr_q)
);

// File: tb/tb_ctlg_top.sv
module tb_ctlg_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b1, wp = 1'b0, mon2 = 1'b0, mon3 = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_kind = 2'd3;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0] cmd_data = 8'h00;
  logic res_valid, res_ok;
  logic [1:0] res_kind;
  logic [AW-1:0] res_addr;
  logic [7:0] res_data, cr_q;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctlg_top #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wp(wp),
    .mon2_fail(mon2), .mon3_fail(mon3),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .res_valid(res_valid), .res_ok(res_ok), .res_kind(res_kind),
    .res_addr(res_addr), .res_data(res_data), .cr_q(cr_q)
  );

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one command; on return the verdict of that command is on the outputs
  task automatic send(input int kind, input int addr, input int data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = 2'(kind); cmd_addr = AW'(addr); cmd_data = 8'(data);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_kind = 2'd3;
  endtask

  task automatic expect_cr(input int exp, input string req);
    chk(cr_q == 8'(exp), req, cr_q, exp);
  endtask

  task automatic expect_ok(input int exp, input string req);
    chk(res_valid === 1'b1 && res_ok == 1'(exp), req, {res_valid, res_ok}, {1'b1, 1'(exp)});
  endtask

  task automatic t_reset;
    chk(cr_q == 8'h00, "R1 cr after reset", cr_q, 0);
    chk(res_valid == 1'b0, "R1 res_valid after reset", res_valid, 0);
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
  endtask

  task automatic t_unlock_sequence;
    send(0, 0, 8'h06);
    expect_ok(0, "R3 unlock without arm refused");
    expect_cr(8'h00, "R3 cr unchanged");
    send(0, 5, 8'h02);
    expect_cr(8'h02, "R2 arm sets bit1");
    chk(res_kind == 2'd0 && res_addr == AW'(5) && res_data == 8'h02, "R11 echo", res_data, 2);
    @(negedge clk);
    chk(res_valid == 1'b0, "R11 single pulse", res_valid, 0);
    send(0, 0, 8'h06);
    expect_cr(8'h06, "R3 unlock after arm");
    send(0, 0, 8'h08);
    expect_cr(8'h08, "R4 commit lock 01 clears latches");
    send(0, 0, 8'h7F);
    expect_cr(8'h08, "R4 stray write ignored");
    expect_ok(0, "R4 stray write refused");
  endtask

  task automatic set_lock(input int data, input int exp_after);
    send(0, 0, 8'h02);
    send(0, 0, 8'h06);
    send(0, 0, data);
    expect_cr(exp_after, "R4 commit value");
  endtask

  task automatic t_lock_regions;
    send(2, 0, 8'h55);
    expect_ok(0, "R6 memory write without wel");
    send(0, 0, 8'h02);
    send(2, 47, 8'h11);
    expect_ok(1, "R7 lock01 below 48");
    send(2, 48, 8'h11);
    expect_ok(0, "R7 lock01 at 48");
    send(1, 0, 8'h20);
    expect_ok(0, "R5 wiper frozen by lock");
    set_lock(8'h10, 8'h10);
    send(0, 0, 8'h02);
    send(2, 31, 8'h11);
    expect_ok(1, "R7 lock10 below 32");
    send(2, 32, 8'h11);
    expect_ok(0, "R7 lock10 at 32");
    set_lock(8'h18, 8'h18);
    send(0, 0, 8'h02);
    send(2, 0, 8'h11);
    expect_ok(0, "R7 lock11 address 0");
    set_lock(8'h00, 8'h00);
    send(0, 0, 8'h02);
    send(1, 0, 8'h40);
    expect_ok(1, "R5 wiper granted");
    send(2, 63, 8'h11);
    expect_ok(1, "R7 lock00 top address");
    send(3, 0, 8'h00);
    expect_ok(0, "R11 kind3 refused");
  endtask

  task automatic t_write_protect;
    @(negedge clk); wp = 1'b1;
    send(1, 0, 8'h40);
    expect_ok(0, "R8 wiper under wp");
    send(2, 1, 8'h40);
    expect_ok(0, "R8 memory under wp");
    send(0, 0, 8'h06);
    send(0, 0, 8'h78);
    expect_cr(8'h60, "R8 commit keeps lock, loads flags");
    @(negedge clk); wp = 1'b0;
  endtask

  task automatic t_monitors;
    @(negedge clk); mon2 = 1'b1;
    @(negedge clk);
    expect_cr(8'h40, "R9 mon2 rise clears bit5");
    @(negedge clk); mon3 = 1'b1;
    @(negedge clk);
    expect_cr(8'h00, "R9 mon3 rise clears bit6");
    set_lock(8'h60, 8'h60);
    repeat (3) @(negedge clk);
    expect_cr(8'h60, "R9 steady level keeps flags");
    mon2 = 1'b0;
    @(negedge clk); mon2 = 1'b1;
    @(negedge clk);
    expect_cr(8'h40, "R9 second rise clears bit5");
  endtask

  task automatic t_power;
    set_lock(8'h68, 8'h68);
    send(0, 0, 8'h02);
    expect_cr(8'h6A, "R10 armed before loss");
    @(negedge clk); supply_ok = 1'b0;
    @(negedge clk);
    expect_cr(8'h08, "R10 volatile cleared, lock kept");
    chk(cmd_ready == 1'b0, "R10 ready low", cmd_ready, 0);
    send(0, 0, 8'h02);
    chk(res_valid == 1'b0, "R10 command not taken", res_valid, 0);
    expect_cr(8'h08, "R10 arm ignored while down");
    @(negedge clk); supply_ok = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R10 ready returns", cmd_ready, 1);
    expect_cr(8'h08, "R10 lock survives");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unlock_sequence();
    t_lock_regions();
    t_write_protect();
    t_monitors();
    t_power();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule